// File: doc/BRIEF.md
# NAK Retry Timeout Interrupt Timer

This block measures how long a host controller has been retrying a transfer that the device keeps answering with NAK. A 1 ms tick advances a counter once retrying has begun. When the count reaches a limit that software has programmed, the block sets a sticky status bit and raises a level interrupt. A programmed limit of zero switches the time-out off. Software programs zero when it needs no time-out indication, or when no transfer descriptor is waiting in the buffer.

A second source drives the same interrupt. It counts completed transfer descriptors against a programmable threshold. Each source has its own status bit, and software clears a bit by writing 1 to it. Three registers sit behind one word-wide write port with a two-bit address:

- Address 0 holds the time-out limit in bits 7:0.
- Address 1 holds the completed-descriptor threshold in bits 7:0.
- Address 2 is the status register.

In every register the upper bits are reserved. They read as zero and writes to them have no effect.

Top module: `nak_tmo_top`

## Requirements
- R1: After reset the limit and threshold registers read 0000h, the status register reads 0000h, and `irq` is low.
- R2: At addresses 0 and 1 only bits 7:0 are stored. Bits 15:8 of any register read back as 0, whatever was written there. Address 3 reads 0000h, and writes to address 3 have no effect.
- R3: While the limit is 0, no number of NAK retries or ticks sets status bit 0.
- R4: Counting is armed by a NAK retry pulse while `ptd_active` is high. With a nonzero limit L, status bit 0 is set on the L-th `ms_tick` after arming. It is not set after L-1 ticks. This holds for L = 1 and L = 255.
- R5: A `ptd_done` pulse discards the running count and disarms the timer. A later NAK retry starts a fresh count of L ticks.
- R6: While `ptd_active` is low, the count is held at zero and the timer is disarmed.
- R7: Status bits are sticky. A status bit stays set until software writes 1 to that bit position at address 2. Writing 0 to a bit position leaves that bit unchanged.
- R8: A write to address 0 discards any running count and disarms the timer, even when the written value is unchanged.
- R9: Without a NAK retry, ticks never advance the timer.
- R10: With a nonzero threshold N at address 1, the N-th `ptd_done` pulse sets status bit 1. The count then restarts from zero. A threshold of 0 disables this source.
- R11: `irq` is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| nak_retry | input | 1 | One-cycle pulse per NAK-answered retry |
| ptd_done | input | 1 | One-cycle pulse per completed descriptor |
| ptd_active | input | 1 | High while any descriptor is active |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | Level interrupt |
| status | output | 2 | Bit 0 time-out, bit 1 done-count |

## Verification
The assertions are evaluated on every cycle. They check four things:
- a time-out event only follows a tick, and the count stays below a nonzero limit;
- a zero limit or zero threshold produces no event;
- a completed descriptor and a limit write both leave the timer disarmed;
- status bits hold until a 1 is written to them.

The bench scenarios show the end-to-end numbers, which no single-cycle property captures. These are the exact tick count at which the interrupt appears for limits of 1, 3 and 255, and the restart after a descriptor completes or the limit is rewritten. The scenarios also show that reserved bits read back as zero and that the two sources combine into one interrupt.

// File: rtl/nak_tmo_pkg.sv
package nak_tmo_pkg;
    localparam int REG_W   = 16;
    localparam int FIELD_W = 8;
    localparam int ADDR_W  = 2;
    localparam int STAT_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LIMIT  = 2'd0,
        ADR_THRESH = 2'd1,
        ADR_STATUS = 2'd2,
        ADR_NONE   = 2'd3
    } reg_addr_e;

    typedef enum int {
        ST_TMO  = 0,
        ST_DONE = 1
    } stat_bit_e;

    typedef struct packed {
        logic              wr;
        reg_addr_e         addr;
        logic [REG_W-1:0]  data;
    } reg_req_t;

    function automatic logic [REG_W-1:0] widen(input logic [FIELD_W-1:0] f);
        return {{(REG_W-FIELD_W){1'b0}}, f};
    endfunction

    function automatic logic hits(input logic [FIELD_W-1:0] cnt,
                                  input logic [FIELD_W-1:0] lim);
        return ({1'b0, cnt} + {{FIELD_W{1'b0}}, 1'b1}) == {1'b0, lim};
    endfunction
endpackage

// File: rtl/nak_tmo_regs.sv
module nak_tmo_regs
    import nak_tmo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_req_t             req,
    input  reg_addr_e            rd_addr,
    input  logic                 set_tmo,
    input  logic                 set_done,
    output logic [FIELD_W-1:0]   limit,
    output logic [FIELD_W-1:0]   thresh,
    output logic                 limit_wr,
    output logic                 thresh_wr,
    output logic [STAT_W-1:0]    status,
    output logic [REG_W-1:0]     rdata
);
    logic [FIELD_W-1:0] limit_q, thresh_q;
    logic [STAT_W-1:0]  stat_q, stat_set, stat_clr;
    logic               unused_hi;

    assign unused_hi = ^req.data[REG_W-1:STAT_W];

    assign limit_wr  = req.wr && (req.addr == ADR_LIMIT);
    assign thresh_wr = req.wr && (req.addr == ADR_THRESH);

    always_comb begin
        stat_set = '0;
        stat_set[ST_TMO]  = set_tmo;
        stat_set[ST_DONE] = set_done;
        stat_clr = (req.wr && req.addr == ADR_STATUS) ? req.data[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q  <= '0;
            thresh_q <= '0;
            stat_q   <= '0;
        end else begin
            if (limit_wr)  limit_q  <= req.data[FIELD_W-1:0];
            if (thresh_wr) thresh_q <= req.data[FIELD_W-1:0];
            stat_q <= (stat_q & ~stat_clr) | stat_set;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADR_LIMIT:  rdata = widen(limit_q);
            ADR_THRESH: rdata = widen(thresh_q);
            ADR_STATUS: rdata = {{(REG_W-STAT_W){1'b0}}, stat_q};
            default:    rdata = '0;
        endcase
    end

    assign limit  = limit_q;
    assign thresh = thresh_q;
    assign status = stat_q;

    // R7: a set status bit holds unless a 1 is written to it
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_q[ST_TMO] && !(req.wr && req.addr == ADR_STATUS && req.data[ST_TMO]))
        |=> stat_q[ST_TMO]);

    // R2: only the low field of a limit write is captured
    a_r2_limit_capture: assert property (@(posedge clk) disable iff (rst)
        limit_wr |=> (limit_q == $past(req.data[FIELD_W-1:0])));
endmodule

// File: rtl/nak_tmo_timer.sv
module nak_tmo_timer
    import nak_tmo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ms_tick,
    input  logic                nak_retry,
    input  logic                ptd_done,
    input  logic                ptd_active,
    input  logic [FIELD_W-1:0]  limit,
    input  logic                limit_wr,
    output logic                expire
);
    logic               running;
    logic [FIELD_W-1:0] cnt;
    logic               clr;

    assign clr = ptd_done || !ptd_active || limit_wr || (limit == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            running <= 1'b0;
            cnt     <= '0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (running) begin
                if (ms_tick) begin
                    if (hits(cnt, limit)) begin
                        expire  <= 1'b1;
                        running <= 1'b0;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end else if (nak_retry) begin
                running <= 1'b1;
                cnt     <= '0;
            end
        end
    end

    // R4: a time-out event only follows a tick
    a_r4_expire_after_tick: assert property (@(posedge clk) disable iff (rst)
        expire |-> $past(ms_tick));

    // R4: the running count stays below the limit
    a_r4_count_below_limit: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < limit));

    // R3: a zero limit never yields an event
    a_r3_zero_limit_off: assert property (@(posedge clk) disable iff (rst)
        (limit == '0) |=> !expire);

    // R5: a completed descriptor disarms the timer
    a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
        ptd_done |=> (!running && cnt == '0));

    // R8: a limit write disarms the timer
    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        limit_wr |=> !running);
endmodule

// File: rtl/nak_tmo_done_cnt.sv
module nak_tmo_done_cnt
    import nak_tmo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ptd_done,
    input  logic [FIELD_W-1:0]  thresh,
    input  logic                thresh_wr,
    output logic                hit
);
    logic [FIELD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || thresh_wr || thresh == '0) begin
            cnt <= '0;
            hit <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (ptd_done) begin
                if (hits(cnt, thresh)) begin
                    hit <= 1'b1;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10: a zero threshold never yields an event
    a_r10_zero_thresh_off: assert property (@(posedge clk) disable iff (rst)
        (thresh == '0) |=> !hit);

    // R10: an event only follows a completed descriptor
    a_r10_hit_after_done: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(ptd_done));
endmodule

// File: rtl/nak_tmo_top.sv
module nak_tmo_top
    import nak_tmo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ms_tick,
    input  logic                nak_retry,
    input  logic                ptd_done,
    input  logic                ptd_active,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq,
    output logic [STAT_W-1:0]   status
);
    reg_req_t           req;
    logic [FIELD_W-1:0] limit, thresh;
    logic               limit_wr, thresh_wr, expire, hit;

    assign req.wr   = reg_wr;
    assign req.addr = reg_addr_e'(reg_addr);
    assign req.data = reg_wdata;

    nak_tmo_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .rd_addr(reg_addr_e'(reg_addr)),
        .set_tmo(expire), .set_done(hit),
        .limit(limit), .thresh(thresh),
        .limit_wr(limit_wr), .thresh_wr(thresh_wr),
        .status(status), .rdata(reg_rdata)
    );

    nak_tmo_timer u_timer (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .nak_retry(nak_retry),
        .ptd_done(ptd_done), .ptd_active(ptd_active),
        .limit(limit), .limit_wr(limit_wr), .expire(expire)
    );

    nak_tmo_done_cnt u_done (
        .clk(clk), .rst(rst), .ptd_done(ptd_done),
        .thresh(thresh), .thresh_wr(thresh_wr), .hit(hit)
    );

    assign irq = |status;
endmodule

// File: tb/nak_tmo_top_bench.sv
module nak_tmo_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0, nak_retry = 1'b0, ptd_done = 1'b0, ptd_active = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [1:0]  status;
    int checks = 0, errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    nak_tmo_top u_nak_tmo_top (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .nak_retry(nak_retry),
        .ptd_done(ptd_done), .ptd_active(ptd_active), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .status(status)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'h0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
        idle(2);
    endtask

    task automatic nak();
        @(negedge clk); nak_retry = 1'b1;
        @(negedge clk); nak_retry = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); ptd_done = 1'b1;
        @(negedge clk); ptd_done = 1'b0;
        idle(2);
    endtask

    task automatic clear_all();
        wr(2'd2, 16'h0003);
        idle(1);
    endtask

    task automatic t_reset();
        rd_chk("R1 limit", 2'd0, 16'h0);
        rd_chk("R1 thresh", 2'd1, 16'h0);
        rd_chk("R1 status", 2'd2, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_reserved();
        wr(2'd0, 16'hAB05);
        rd_chk("R2 limit upper bits", 2'd0, 16'h0005);
        wr(2'd1, 16'hFF00);
        rd_chk("R2 thresh upper bits", 2'd1, 16'h0000);
        wr(2'd3, 16'hFFFF);
        rd_chk("R2 addr3 reads zero", 2'd3, 16'h0000);
        rd_chk("R2 addr3 write no effect", 2'd0, 16'h0005);
        chk("R2 addr3 no status", {14'h0, status}, 16'h0);
    endtask

    task automatic t_fire3();
        wr(2'd0, 16'h0003);
        nak();
        tick(2);
        chk("R4 no irq after L-1 ticks", {15'h0, irq}, 16'h0);
        tick(1);
        chk("R4 irq after L ticks", {15'h0, irq}, 16'h1);
        chk("R4 status bit0", {14'h0, status}, 16'h1);
    endtask

    task automatic t_sticky();
        tick(3);
        chk("R7 stays set", {14'h0, status}, 16'h1);
        wr(2'd2, 16'h0002);
        idle(1);
        chk("R7 writing 0 keeps bit0", {14'h0, status}, 16'h1);
        wr(2'd2, 16'h0001);
        idle(1);
        chk("R7 W1C clears bit0", {14'h0, status}, 16'h0);
        chk("R11 irq low after clear", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_done_clears();
        nak();
        tick(2);
        done_pulse();
        tick(2);
        chk("R5 done discards count", {15'h0, irq}, 16'h0);
        nak();
        tick(2);
        chk("R5 fresh count not early", {15'h0, irq}, 16'h0);
        tick(1);
        chk("R5 fresh count fires", {15'h0, irq}, 16'h1);
        clear_all();
    endtask

    task automatic t_inactive();
        nak();
        tick(2);
        @(negedge clk); ptd_active = 1'b0;
        @(negedge clk); ptd_active = 1'b1;
        tick(2);
        chk("R6 inactive discards count", {15'h0, irq}, 16'h0);
        @(negedge clk); ptd_active = 1'b0;
        nak();
        tick(4);
        chk("R6 no arming while inactive", {15'h0, irq}, 16'h0);
        @(negedge clk); ptd_active = 1'b1;
    endtask

    task automatic t_no_nak();
        tick(6);
        chk("R9 ticks without NAK", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_limit_write();
        nak();
        tick(2);
        wr(2'd0, 16'h0003);
        tick(2);
        chk("R8 rewrite discards count", {15'h0, irq}, 16'h0);
        nak();
        tick(3);
        chk("R8 restart fires", {15'h0, irq}, 16'h1);
        clear_all();
    endtask

    task automatic t_zero();
        wr(2'd0, 16'h0000);
        for (int i = 0; i < 5; i++) begin
            nak();
            tick(60);
        end
        chk("R3 zero limit off", {14'h0, status}, 16'h0);
    endtask

    task automatic t_bounds();
        wr(2'd0, 16'h0001);
        nak();
        idle(2);
        chk("R4 L=1 before tick", {15'h0, irq}, 16'h0);
        tick(1);
        chk("R4 L=1 fires", {15'h0, irq}, 16'h1);
        clear_all();
        wr(2'd0, 16'h00FF);
        nak();
        tick(254);
        chk("R4 L=255 not at 254", {15'h0, irq}, 16'h0);
        tick(1);
        chk("R4 L=255 fires", {15'h0, irq}, 16'h1);
        clear_all();
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_done_thresh();
        done_pulse();
        chk("R10 zero thresh off", {14'h0, status}, 16'h0);
        wr(2'd1, 16'h0002);
        done_pulse();
        chk("R10 not at N-1", {14'h0, status}, 16'h0);
        done_pulse();
        chk("R10 status bit1", {14'h0, status}, 16'h2);
        chk("R11 irq from done source", {15'h0, irq}, 16'h1);
        rd_chk("R10 status readback", 2'd2, 16'h0002);
        wr(2'd2, 16'h0002);
        idle(1);
        chk("R10 clear bit1", {15'h0, irq}, 16'h0);
        done_pulse();
        chk("R10 restart from zero", {14'h0, status}, 16'h0);
        done_pulse();
        chk("R10 second event", {14'h0, status}, 16'h2);
        wr(2'd0, 16'h0001);
        nak();
        tick(1);
        chk("R11 both sources", {14'h0, status}, 16'h3);
        wr(2'd2, 16'h0002);
        idle(1);
        chk("R11 irq with bit0 only", {15'h0, irq}, 16'h1);
        clear_all();
        chk("R11 irq low", {15'h0, irq}, 16'h0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        ptd_active = 1'b1;
        t_reserved();
        t_fire3();
        t_sticky();
        t_done_clears();
        t_inactive();
        t_no_nak();
        t_limit_write();
        t_zero();
        t_bounds();
        t_done_thresh();
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule